// File: doc/BRIEF.md
# Event Performance Monitor Unit

The block counts what a processor core is doing. A 32-bit cycle counter runs on the clock, either every cycle or once per 64 cycles. Four 32-bit event counters each follow one of 23 single-cycle event strobes, picked by an 8-bit code. Software programs the unit through a small synchronous register port.

For sampling, software loads a counter with the two's-complement negative of a period. It then enables that counter's interrupt. When the counter wraps past all ones, a sticky overflow flag is set and the level interrupt output rises. The interrupt stays high until software writes a 1 to the flag to clear it. Flags only gather: a second wrap never removes a flag that is already set.

Top module: `epm_unit`

## Requirements
- R1: After reset the unit holds these values, and `irq` is 0:
  - control reads the version constant in bits 31:24 and 0 in every other bit;
  - all counters, the interrupt enable register and the overflow flags are 0;
  - the event select register is 0xFFFFFFFF.
- R2: Register addresses are:
  - 0 for control, 1 for the cycle counter, 2 for interrupt enable, 3 for overflow flags, 4 for event select, and 5 to 8 for event counters 0 to 3;
  - a read returns its data on `reg_rdata` one cycle after the request;
  - written counters, interrupt enable and event select read back as written.
- R3: Control fields are as follows:
  - bit 0 enables counting and bit 3 selects divide-by-64 for the cycle counter; both read back as written;
  - bits 1 and 2 are commands and always read 0;
  - bits 23:4 always read 0;
  - bits 31:24 read the version constant and ignore writes.
- R4: No counter advances while control bit 0 is 0. While it is 1, the cycle counter (without divide) advances on every clock edge.
- R5: Event select byte i (bits 8i+7:8i) is the code for event counter i. The counter advances in each enabled cycle where `ev_strobe[code]` is 1. A code of 23 or more, 0xFF included, never advances the counter.
- R6: Control reset commands act as follows:
  - writing control with bit 1 set zeroes the four event counters and leaves the cycle counter alone;
  - writing control with bit 2 set zeroes the cycle counter and leaves the event counters alone.
- R7: With bit 3 set, the cycle counter advances once per 64 enabled cycles. The divider restarts whenever bit 3 changes value, and whenever a cycle counter reset command is written.
- R8: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag. The flag bits are bit 0 for the cycle counter and bits 1 to 4 for event counters 0 to 3. The interrupt enable register uses the same bit map.
- R9: Overflow flags behave as follows:
  - writing 1 to a flag bit clears it, and writing 0 leaves it unchanged;
  - a wrap in the same cycle as a clear leaves the flag set;
  - a wrap never clears any flag.
- R10: `irq` is high exactly when some flag is set with its enable bit also set. It follows a flag change after the same clock edge, and stays high until those flags or enables are cleared.
- R11: A port write to a counter in the same cycle as an increment of that counter loads the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_strobe | input | 23 | Single-cycle event strobes, indexed by event code |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
A flag that is wrongly set or lost shows on `irq` after the very next clock edge once its enable bit is set. A read of register 3 shows it one cycle after the request. A wrong counter state, such as a lost increment, a wrong event source or a divider phase left over from before a restart, stays inside the counter until it is read or until it shifts the wrap point. The bench therefore reads every counter back right after each counting burst. It also drives counters to one or two steps below the wrap, so an error becomes a missing or early flag within one or two cycles.

// File: rtl/epm_pkg.sv
// Shared constants for the event performance monitor.
// Assumes a 4-bit register address and the control bit positions below.
package epm_pkg;
    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_CYC   = 4'd1;
    localparam logic [3:0] A_IEN   = 4'd2;
    localparam logic [3:0] A_OVF   = 4'd3;
    localparam logic [3:0] A_EVSEL = 4'd4;
    localparam logic [3:0] A_EV0   = 4'd5;

    localparam int C_EN    = 0;
    localparam int C_EVRST = 1;
    localparam int C_CYRST = 2;
    localparam int C_DIV   = 3;

    typedef struct packed {
        logic div64;
        logic en;
    } epm_ctrl_t;
endpackage

// File: rtl/epm_prescale.sv
// Divide-by-DIV tick generator for the cycle counter.
// Counts only while en is high; restart returns it to phase 0.
// The tick is combinational and high on the last enabled cycle of a period.
module epm_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Phase counter; wraps at DIV-1, restart takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase_q <= '0;
        else if (en)
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    assign tick = en && (phase_q == LAST);
endmodule

// File: rtl/epm_counter.sv
// One W-bit monitor counter with load, clear and increment.
// Load beats clear, and clear beats increment.
// wrap pulses when an increment takes the counter from all ones to zero.
module epm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    // Counter state update with load, clear and increment priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (ld)
            value <= ld_val;
        else if (clr)
            value <= '0;
        else if (inc)
            value <= value + 1'b1;
    end

    assign wrap = inc && !ld && !clr && (&value);
endmodule

// File: rtl/epm_evsel.sv
// Event source picker: hit is the strobe whose index equals code.
// A code outside 0..NUM_EVENTS-1 never hits.
module epm_evsel #(
    parameter int NUM_EVENTS = 23,
    parameter int CODE_W     = 8
) (
    input  logic [CODE_W-1:0]     code,
    input  logic [NUM_EVENTS-1:0] strobes,
    output logic                  hit
);
    // Compare the code against every valid index.
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NUM_EVENTS; k++)
            if (code == CODE_W'(k))
                hit = hit | strobes[k];
    end
endmodule

// File: rtl/epm_unit.sv
// Event performance monitor top.
// Holds one cycle counter and NUM_EVC event counters, plus the control,
// event select, interrupt enable and sticky overflow flag registers.
// Assumes DATA_W = 32, with 8-bit event codes packed into event select.
// Reads are registered, so data follows the request by one cycle.
module epm_unit #(
    parameter int         DATA_W     = 32,
    parameter int         NUM_EVC    = 4,
    parameter int         NUM_EVENTS = 23,
    parameter int         CODE_W     = 8,
    parameter int         PRESCALE   = 64,
    parameter int         ADDR_W     = 4,
    parameter logic [7:0] VERSION    = 8'h2A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] ev_strobe,
    input  logic                  reg_req,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq
);
    import epm_pkg::*;

    localparam int NF    = NUM_EVC + 1;
    localparam int SEL_W = NUM_EVC * CODE_W;
    localparam int GAP_W = DATA_W - 8 - 4;

    epm_ctrl_t          ctrl_q;
    logic [NF-1:0]      ien_q;
    logic [NF-1:0]      ovf_q;
    logic [SEL_W-1:0]   evsel_q;
    logic [DATA_W-1:0]  cyc_val;
    logic [DATA_W-1:0]  ev_val [NUM_EVC];
    logic [NF-1:0]      wraps;
    logic               wr_hit, ctrl_wr, ev_rst_cmd, cyc_rst_cmd, div_chg;
    logic               pre_tick, cyc_inc, ctrl_en;
    logic [DATA_W-1:0]  rd_mux;

    assign wr_hit      = reg_req && reg_wr;
    assign ctrl_wr     = wr_hit && (reg_addr == A_CTRL);
    assign ev_rst_cmd  = ctrl_wr && reg_wdata[C_EVRST];
    assign cyc_rst_cmd = ctrl_wr && reg_wdata[C_CYRST];
    assign div_chg     = ctrl_wr && (reg_wdata[C_DIV] != ctrl_q.div64);
    assign ctrl_en     = ctrl_q.en;

    // Control register: enable and divide select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr) begin
            ctrl_q.en    <= reg_wdata[C_EN];
            ctrl_q.div64 <= reg_wdata[C_DIV];
        end
    end

    // Interrupt enable and event select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q   <= '0;
            evsel_q <= '1;
        end else if (wr_hit) begin
            if (reg_addr == A_IEN)
                ien_q <= reg_wdata[NF-1:0];
            if (reg_addr == A_EVSEL)
                evsel_q <= reg_wdata[SEL_W-1:0];
        end
    end

    // Sticky overflow flags: a new wrap beats a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else if (wr_hit && (reg_addr == A_OVF))
            ovf_q <= (ovf_q & ~reg_wdata[NF-1:0]) | wraps;
        else
            ovf_q <= ovf_q | wraps;
    end

    epm_prescale #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_en),
        .restart (div_chg || cyc_rst_cmd),
        .tick    (pre_tick)
    );

    assign cyc_inc = ctrl_en && (!ctrl_q.div64 || pre_tick);

    epm_counter #(.W(DATA_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cyc_rst_cmd),
        .ld     (wr_hit && (reg_addr == A_CYC)),
        .ld_val (reg_wdata),
        .inc    (cyc_inc),
        .value  (cyc_val),
        .wrap   (wraps[0])
    );

    for (genvar i = 0; i < NUM_EVC; i++) begin : g_ev
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_EV0) + i);
        logic hit;

        epm_evsel #(.NUM_EVENTS(NUM_EVENTS), .CODE_W(CODE_W)) u_sel (
            .code    (evsel_q[i*CODE_W +: CODE_W]),
            .strobes (ev_strobe),
            .hit     (hit)
        );

        epm_counter #(.W(DATA_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (ev_rst_cmd),
            .ld     (wr_hit && (reg_addr == MY_ADDR)),
            .ld_val (reg_wdata),
            .inc    (ctrl_en && hit),
            .value  (ev_val[i]),
            .wrap   (wraps[i+1])
        );
    end

    // Read data selection by address.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_CTRL)
            rd_mux = {VERSION, {GAP_W{1'b0}}, ctrl_q.div64, 2'b00, ctrl_q.en};
        else if (reg_addr == A_CYC)
            rd_mux = cyc_val;
        else if (reg_addr == A_IEN)
            rd_mux = DATA_W'(ien_q);
        else if (reg_addr == A_OVF)
            rd_mux = DATA_W'(ovf_q);
        else if (reg_addr == A_EVSEL)
            rd_mux = DATA_W'(evsel_q);
        for (int i = 0; i < NUM_EVC; i++)
            if (reg_addr == ADDR_W'(int'(A_EV0) + i))
                rd_mux = ev_val[i];
    end

    // Registered read port: updates only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_req && !reg_wr)
            reg_rdata <= rd_mux;
    end

    assign irq = |(ovf_q & ien_q);
endmodule

// File: rtl/epm_unit_chk.sv
// Property checker for epm_unit, attached through bind.
// Watches the register port, the flags and the cycle counter path.
module epm_unit_chk #(
    parameter int DATA_W = 32,
    parameter int NF     = 5,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              ctrl_en,
    input logic              cyc_inc,
    input logic              cyc_rst_cmd,
    input logic [DATA_W-1:0] cyc_val,
    input logic [NF-1:0]     ovf_q
);
    import epm_pkg::*;

    logic any_wr;
    assign any_wr = reg_req && reg_wr;

    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(any_wr && reg_addr == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(any_wr && (reg_addr == A_OVF || reg_addr == A_IEN))) |=> irq);

    a_r8_cyc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_val == '1 && cyc_inc && !cyc_rst_cmd && !(any_wr && reg_addr == A_CYC))
        |=> ovf_q[0]);

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !any_wr) |=> $stable(cyc_val));

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && !reg_wr) |=> $stable(reg_rdata));

    a_r3_ctrl_gaps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr && reg_addr == A_CTRL)
        |=> (reg_rdata[23:4] == '0 && reg_rdata[2:1] == 2'b00));
endmodule

bind epm_unit epm_unit_chk #(.DATA_W(DATA_W), .NF(NF), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_req     (reg_req),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .ctrl_en     (ctrl_en),
    .cyc_inc     (cyc_inc),
    .cyc_rst_cmd (cyc_rst_cmd),
    .cyc_val     (cyc_val),
    .ovf_q       (ovf_q)
);

// File: tb/epm_unit_test.sv
// Scoreboard bench for epm_unit: the read task queues the expected values,
// and the monitor compares them when read data appears.
module epm_unit_test;
    localparam int NE = 23;
    localparam logic [7:0] VER = 8'h2A;
    localparam logic [31:0] VERW = {VER, 24'h0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NE-1:0] ev_strobe = '0;
    logic reg_req = 1'b0, reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq;

    typedef struct {
        int          rid;
        logic [31:0] exp;
    } item_t;

    item_t exp_q[$];
    int n_run = 0, n_fail = 0;
    logic pend = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    epm_unit #(.VERSION(VER)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_strobe (ev_strobe),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Track reads accepted at each edge.
    always @(posedge clk) pend <= rst_n && reg_req && !reg_wr;

    // Monitor: pop and compare one expected item per returned read.
    always @(negedge clk) begin
        if (pend) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected read data %h expected none", reg_rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL R%0d read got %h expected %h", it.rid, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input int rid);
        item_t it;
        it.rid = rid; it.exp = e;
        exp_q.push_back(it);
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic pulse(input logic [NE-1:0] v, input int n);
        ev_strobe = v;
        repeat (n) @(negedge clk);
        ev_strobe = '0;
    endtask

    task automatic chk(input int rid, input logic act, input logic e);
        n_run++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL R%0d irq got %b expected %b", rid, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, irq, 1'b0);
        rd(4'd0, VERW, 1);
        rd(4'd1, 32'h0, 1);
        rd(4'd2, 32'h0, 1);
        rd(4'd3, 32'h0, 1);
        rd(4'd4, 32'hFFFF_FFFF, 1);
        rd(4'd5, 32'h0, 1);
        // R3 control field masking
        wr(4'd0, 32'hFFFF_FFF8);
        rd(4'd0, VERW | 32'h8, 3);
        wr(4'd0, 32'h0);
        // R2 readback of select and enable registers
        wr(4'd4, 32'h16FF_0705);
        rd(4'd4, 32'h16FF_0705, 2);
        wr(4'd2, 32'h15);
        rd(4'd2, 32'h15, 2);
        wr(4'd2, 32'h0);
        // R4 disabled: no counting
        pulse('1, 3);
        rd(4'd5, 32'h0, 4);
        // R5 event selection
        wr(4'd0, 32'h1);
        pulse(NE'(1) << 5, 5);
        pulse((NE'(1) << 7) | (NE'(1) << 22), 3);
        pulse('1, 2);
        wr(4'd0, 32'h0);
        rd(4'd5, 32'd7, 5);
        rd(4'd6, 32'd5, 5);
        rd(4'd7, 32'd0, 5);
        rd(4'd8, 32'd5, 5);
        pulse('1, 4);
        rd(4'd5, 32'd7, 4);
        // R6 reset commands
        wr(4'd0, 32'h4);
        rd(4'd1, 32'h0, 6);
        rd(4'd5, 32'd7, 6);
        wr(4'd0, 32'h2);
        rd(4'd5, 32'h0, 6);
        rd(4'd8, 32'h0, 6);
        rd(4'd0, VERW, 3);
        // R4 cycle counter counts enabled edges
        wr(4'd0, 32'h1);
        repeat (9) @(negedge clk);
        wr(4'd0, 32'h0);
        rd(4'd1, 32'd10, 4);
        // R7 divide by 64
        wr(4'd0, 32'hC);
        wr(4'd0, 32'h9);
        repeat (129) @(negedge clk);
        wr(4'd0, 32'h8);
        rd(4'd1, 32'd2, 7);
        wr(4'd0, 32'hD);
        repeat (62) @(negedge clk);
        wr(4'd0, 32'h8);
        rd(4'd1, 32'd0, 7);
        wr(4'd0, 32'h9);
        wr(4'd0, 32'h8);
        rd(4'd1, 32'd1, 7);
        // R8 overflow of event counter 0
        wr(4'd0, 32'h0);
        wr(4'd2, 32'h02);
        wr(4'd5, 32'hFFFF_FFFE);
        wr(4'd0, 32'h1);
        pulse(NE'(1) << 5, 1);
        chk(10, irq, 1'b0);
        rd(4'd3, 32'h0, 8);
        pulse(NE'(1) << 5, 1);
        chk(10, irq, 1'b1);
        rd(4'd3, 32'h02, 8);
        rd(4'd5, 32'h0, 8);
        // R9 flags accumulate
        wr(4'd6, 32'hFFFF_FFFF);
        pulse(NE'(1) << 7, 1);
        rd(4'd3, 32'h06, 9);
        // R8 cycle counter wrap sets bit 0
        wr(4'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(4'd3, 32'h07, 8);
        chk(10, irq, 1'b1);
        // R9 write 0 keeps, write 1 clears
        wr(4'd3, 32'h0);
        rd(4'd3, 32'h07, 9);
        wr(4'd3, 32'h02);
        chk(10, irq, 1'b0);
        rd(4'd3, 32'h05, 9);
        // R9 wrap in the same cycle as a clear keeps the flag
        wr(4'd5, 32'hFFFF_FFFF);
        ev_strobe = NE'(1) << 5;
        wr(4'd3, 32'h02);
        ev_strobe = '0;
        rd(4'd3, 32'h07, 9);
        chk(10, irq, 1'b1);
        // R11 write beats increment
        ev_strobe = NE'(1) << 5;
        wr(4'd5, 32'h100);
        ev_strobe = '0;
        rd(4'd5, 32'h100, 11);
        wr(4'd0, 32'h0);
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 %0d reads never returned, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule